// File: doc/BRIEF.md
# Multi-Class Physical Register Free List

This block keeps the pool of unused physical register tags for the rename stage of an out-of-order core. It holds three independent pools, one each for integer, floating-point and condition-code registers. Each pool is a circular FIFO, so the tag that was freed first is the first to be handed out again. Tag numbers are local to their class: tag 3 in the floating-point pool and tag 3 in the integer pool are different registers.

Rename logic requests one tag per cycle from a chosen class. It gets the tag and a grant in the same cycle. Commit or squash logic returns one tag per cycle together with its class, and the block steers the tag into the matching pool. For every class the block reports a non-empty bit and a free count. Three error pulses flag illegal use. These are a bad class code, a request to an empty pool, and a release into a pool that is already full, which means a register was freed twice. An illegal operation leaves the pool state unchanged.

Top module: `phys_reg_free_list`

## Requirements
- R1: After reset, pool c holds the tags RSV_c up to NUM_c-1 in ascending order, and its count is NUM_c-RSV_c. With the default parameters the counts are 8, 8 and 6, the first tags handed out are 8, 8 and 2, and all error outputs are low.
- R2: Each pool hands out tags in FIFO order. A pool first drains the preloaded tags that remain, then gives out the released tags in the order in which they were released.
- R3: The class code is 2'b00 for integer, 2'b01 for floating point and 2'b10 for condition code. A release changes only the count and contents of the pool its code selects. Equal tag values in different classes are tracked separately.
- R4: The class code 2'b11 is invalid. A release or a request with that code changes no pool, gives no grant, and raises `err_class` for the one cycle after the edge at which it was presented.
- R5: A request to an empty pool is not granted (`alloc_ok` low). It leaves that pool's count at 0 and raises `err_empty` for the one cycle after the edge.
- R6: `free_any[c]` is 1 exactly when the count of class c is non-zero. Bit 0 is integer, bit 1 is floating point and bit 2 is condition code.
- R7: A release into a pool whose count is NUM_c, with no grant from that pool in the same cycle, is dropped. The count stays at NUM_c and `err_overflow` rises for the one cycle after the edge.
- R8: A granted request and a release to the same class in the same cycle are both accepted, and the count of that class does not change. This also holds when the pool is full.
- R9: `alloc_ok` and `alloc_tag` are combinational from the request in the same cycle, and `alloc_tag` is the head of the selected pool. Counts and `free_any` update at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; preloads all pools |
| alloc_req | input | 1 | Request one free tag |
| alloc_cls | input | 2 | Class of the request |
| alloc_ok | output | 1 | Request granted this cycle |
| alloc_tag | output | TAG_W | Granted tag (head of the selected pool) |
| rel_vld | input | 1 | Return one tag |
| rel_cls | input | 2 | Class of the returned tag |
| rel_tag | input | TAG_W | Returned tag |
| free_any | output | 3 | Per-class non-empty indication |
| cnt_int | output | CNT_W | Free integer tags |
| cnt_fp | output | CNT_W | Free floating-point tags |
| cnt_cc | output | CNT_W | Free condition-code tags |
| err_empty | output | 1 | Pulse: request to an empty pool |
| err_class | output | 1 | Pulse: invalid class code |
| err_overflow | output | 1 | Pulse: release into a full pool |

## Verification
The grant and the tag are due in the same cycle as the request. The bench drives inputs just after a falling edge and samples `alloc_ok` and `alloc_tag` one time unit later, before the next rising edge. Counts, `free_any` and the three error pulses come out of registers and are due one edge after the stimulus. The bench samples them one time unit after that rising edge, while the inputs are still held. As a result, each error pulse is checked in the single cycle in which it should be high, and it is checked low again at the following step.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
    typedef enum logic [1:0] {
        CLS_INT = 2'b00,
        CLS_FP  = 2'b01,
        CLS_CC  = 2'b10,
        CLS_BAD = 2'b11
    } rfl_cls_e;

    localparam int NUM_CLS = 3;
endpackage

// File: rtl/rfl_cls_dec.sv
module rfl_cls_dec
    import rfl_pkg::*;
(
    input  logic       vld,
    input  logic [1:0] cls,
    output logic [2:0] hit,
    output logic       bad
);
    always_comb begin
        hit = 3'b000;
        bad = 1'b0;
        if (vld) begin
            case (rfl_cls_e'(cls))
                CLS_INT: hit = 3'b001;
                CLS_FP:  hit = 3'b010;
                CLS_CC:  hit = 3'b100;
                default: bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/rfl_pool.sv
module rfl_pool #(
    parameter int DEPTH = 16,
    parameter int RSV   = 8,
    parameter int TAG_W = 4,
    parameter int CNT_W = 5,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int INIT  = DEPTH - RSV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    output logic             pop_ok,
    output logic             push_drop,
    output logic [TAG_W-1:0] head_tag,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0] slot;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } pool_t;

    pool_t st_q, st_d;
    logic  push_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic pool_t preload();
        pool_t s;
        s = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < INIT) s.slot[i] = TAG_W'(RSV + i);
        end
        s.rd  = '0;
        s.wr  = (INIT >= DEPTH) ? '0 : PTR_W'(INIT);
        s.cnt = CNT_W'(INIT);
        return s;
    endfunction

    always_comb begin
        pop_ok    = pop && (st_q.cnt != '0);
        push_ok   = push && ((st_q.cnt != FULL) || pop_ok);
        push_drop = push && !push_ok;
        st_d      = st_q;
        if (pop_ok) st_d.rd = ptr_inc(st_q.rd);
        if (push_ok) begin
            st_d.slot[st_q.wr] = push_tag;
            st_d.wr            = ptr_inc(st_q.wr);
        end
        if (push_ok && !pop_ok)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= preload();
        else        st_q <= st_d;
    end

    assign head_tag = st_q.slot[st_q.rd];
    assign count    = st_q.cnt;

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && st_q.cnt == FULL) |=> (st_q.cnt == FULL));

    // R5
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.cnt == '0) |=> (st_q.cnt == '0));

    // R8
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && push && st_q.cnt != '0) |=> $stable(st_q.cnt));
endmodule

// File: rtl/phys_reg_free_list.sv
module phys_reg_free_list
    import rfl_pkg::*;
#(
    parameter int NUM_INT = 16,
    parameter int NUM_FP  = 16,
    parameter int NUM_CC  = 8,
    parameter int RSV_INT = 8,
    parameter int RSV_FP  = 8,
    parameter int RSV_CC  = 2,
    localparam int MAX_N  = (NUM_INT > NUM_FP) ? ((NUM_INT > NUM_CC) ? NUM_INT : NUM_CC)
                                               : ((NUM_FP > NUM_CC) ? NUM_FP : NUM_CC),
    localparam int TAG_W  = (MAX_N > 1) ? $clog2(MAX_N) : 1,
    localparam int CNT_W  = $clog2(MAX_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic [1:0]       alloc_cls,
    output logic             alloc_ok,
    output logic [TAG_W-1:0] alloc_tag,
    input  logic             rel_vld,
    input  logic [1:0]       rel_cls,
    input  logic [TAG_W-1:0] rel_tag,
    output logic [2:0]       free_any,
    output logic [CNT_W-1:0] cnt_int,
    output logic [CNT_W-1:0] cnt_fp,
    output logic [CNT_W-1:0] cnt_cc,
    output logic             err_empty,
    output logic             err_class,
    output logic             err_overflow
);
    function automatic int depth_of(int c);
        return (c == 0) ? NUM_INT : (c == 1) ? NUM_FP : NUM_CC;
    endfunction

    function automatic int rsv_of(int c);
        return (c == 0) ? RSV_INT : (c == 1) ? RSV_FP : RSV_CC;
    endfunction

    typedef struct packed {
        logic empty;
        logic cls;
        logic ovf;
    } err_t;

    logic [2:0]       a_hit, r_hit;
    logic             a_bad, r_bad;
    logic [2:0]       granted, dropped;
    logic [TAG_W-1:0] head [NUM_CLS];
    logic [CNT_W-1:0] cnt  [NUM_CLS];
    err_t             err_q, err_d;

    rfl_cls_dec u_alloc_dec (.vld(alloc_req), .cls(alloc_cls), .hit(a_hit), .bad(a_bad));
    rfl_cls_dec u_rel_dec   (.vld(rel_vld),   .cls(rel_cls),   .hit(r_hit), .bad(r_bad));

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_pool
        rfl_pool #(
            .DEPTH (depth_of(g)),
            .RSV   (rsv_of(g)),
            .TAG_W (TAG_W),
            .CNT_W (CNT_W)
        ) u_pool (
            .clk       (clk),
            .rst_n     (rst_n),
            .pop       (a_hit[g]),
            .push      (r_hit[g]),
            .push_tag  (rel_tag),
            .pop_ok    (granted[g]),
            .push_drop (dropped[g]),
            .head_tag  (head[g]),
            .count     (cnt[g])
        );
        assign free_any[g] = (cnt[g] != '0);
    end

    always_comb begin
        alloc_ok  = |granted;
        alloc_tag = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (a_hit[c]) alloc_tag = head[c];
        end
        err_d.empty = (|a_hit) && !alloc_ok;
        err_d.cls   = a_bad || r_bad;
        err_d.ovf   = |dropped;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign cnt_int      = cnt[0];
    assign cnt_fp       = cnt[1];
    assign cnt_cc       = cnt[2];
    assign err_empty    = err_q.empty;
    assign err_class    = err_q.cls;
    assign err_overflow = err_q.ovf;

    // R4
    bad_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_vld && rel_cls == 2'b11) |=> err_class);

    // R9
    grant_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok |-> (alloc_req && (|free_any)));

    // R4
    bad_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_cls == 2'b11) |-> !alloc_ok);
endmodule

// File: tb/tb_phys_reg_free_list.sv
module tb_phys_reg_free_list;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_req = 1'b0;
    logic [1:0] alloc_cls = 2'b00;
    logic       alloc_ok;
    logic [3:0] alloc_tag;
    logic       rel_vld = 1'b0;
    logic [1:0] rel_cls = 2'b00;
    logic [3:0] rel_tag = 4'd0;
    logic [2:0] free_any;
    logic [4:0] cnt_int, cnt_fp, cnt_cc;
    logic       err_empty, err_class, err_overflow;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    phys_reg_free_list dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_cls(alloc_cls),
        .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
        .rel_vld(rel_vld), .rel_cls(rel_cls), .rel_tag(rel_tag),
        .free_any(free_any), .cnt_int(cnt_int), .cnt_fp(cnt_fp), .cnt_cc(cnt_cc),
        .err_empty(err_empty), .err_class(err_class), .err_overflow(err_overflow)
    );

    typedef struct packed {
        logic       a_req;
        logic [1:0] a_cls;
        logic       r_vld;
        logic [1:0] r_cls;
        logic [3:0] r_tag;
        logic       e_ok;
        logic [3:0] e_tag;
        logic [4:0] e_ci;
        logic [4:0] e_cf;
        logic [4:0] e_cc;
        logic [2:0] e_err;   // {overflow, class, empty}
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 1'b0, 2'd0, 4'd0, 1'b1, 4'd8,  5'd7, 5'd8, 5'd6, 3'b000},
        '{1'b1, 2'd1, 1'b0, 2'd0, 4'd0, 1'b1, 4'd8,  5'd7, 5'd7, 5'd6, 3'b000},
        '{1'b1, 2'd2, 1'b0, 2'd0, 4'd0, 1'b1, 4'd2,  5'd7, 5'd7, 5'd5, 3'b000},
        '{1'b0, 2'd0, 1'b1, 2'd0, 4'd3, 1'b0, 4'd0,  5'd8, 5'd7, 5'd5, 3'b000},
        '{1'b0, 2'd0, 1'b1, 2'd1, 4'd3, 1'b0, 4'd0,  5'd8, 5'd8, 5'd5, 3'b000},
        '{1'b1, 2'd0, 1'b1, 2'd0, 4'd5, 1'b1, 4'd9,  5'd8, 5'd8, 5'd5, 3'b000},
        '{1'b0, 2'd0, 1'b1, 2'd3, 4'd1, 1'b0, 4'd0,  5'd8, 5'd8, 5'd5, 3'b010},
        '{1'b1, 2'd3, 1'b0, 2'd0, 4'd0, 1'b0, 4'd0,  5'd8, 5'd8, 5'd5, 3'b010},
        '{1'b1, 2'd2, 1'b0, 2'd0, 4'd0, 1'b1, 4'd3,  5'd8, 5'd8, 5'd4, 3'b000},
        '{1'b1, 2'd0, 1'b1, 2'd2, 4'd2, 1'b1, 4'd10, 5'd7, 5'd8, 5'd5, 3'b000}
    };

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(logic ar, logic [1:0] ac, logic rv, logic [1:0] rc, logic [3:0] rt);
        @(negedge clk);
        alloc_req = ar; alloc_cls = ac;
        rel_vld = rv; rel_cls = rc; rel_tag = rt;
        #1;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 2'd0, 1'b0, 2'd0, 4'd0);
        settle();
    endtask

    initial begin
        #150000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "cnt_int", int'(cnt_int), 8);
        chk("R1", "cnt_fp",  int'(cnt_fp),  8);
        chk("R1", "cnt_cc",  int'(cnt_cc),  6);
        chk("R6", "free_any", int'(free_any), 7);
        chk("R1", "errors", int'({err_overflow, err_class, err_empty}), 0);
        chk("R9", "alloc_ok idle", int'(alloc_ok), 0);

        // Vector table: R1 R3 R4 R8 R9 R6
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].a_req, VEC[i].a_cls, VEC[i].r_vld, VEC[i].r_cls, VEC[i].r_tag);
            chk("R9", $sformatf("v%0d alloc_ok", i), int'(alloc_ok), int'(VEC[i].e_ok));
            if (VEC[i].e_ok)
                chk("R2", $sformatf("v%0d alloc_tag", i), int'(alloc_tag), int'(VEC[i].e_tag));
            settle();
            chk("R3", $sformatf("v%0d cnt_int", i), int'(cnt_int), int'(VEC[i].e_ci));
            chk("R3", $sformatf("v%0d cnt_fp", i),  int'(cnt_fp),  int'(VEC[i].e_cf));
            chk("R3", $sformatf("v%0d cnt_cc", i),  int'(cnt_cc),  int'(VEC[i].e_cc));
            chk("R4", $sformatf("v%0d errors", i),
                int'({err_overflow, err_class, err_empty}), int'(VEC[i].e_err));
            chk("R6", $sformatf("v%0d free_any", i), int'(free_any),
                int'({VEC[i].e_cc != 0, VEC[i].e_cf != 0, VEC[i].e_ci != 0}));
        end

        // R2: drain the integer pool in FIFO order
        begin
            int exp_seq [7] = '{11, 12, 13, 14, 15, 3, 5};
            for (int k = 0; k < 7; k++) begin
                drive(1'b1, 2'd0, 1'b0, 2'd0, 4'd0);
                chk("R2", $sformatf("drain %0d ok", k), int'(alloc_ok), 1);
                chk("R2", $sformatf("drain %0d tag", k), int'(alloc_tag), exp_seq[k]);
                settle();
            end
        end
        chk("R2", "cnt_int drained", int'(cnt_int), 0);
        chk("R6", "free_any int empty", int'(free_any[0]), 0);

        // R5: request to an empty pool
        drive(1'b1, 2'd0, 1'b0, 2'd0, 4'd0);
        chk("R5", "empty alloc_ok", int'(alloc_ok), 0);
        settle();
        chk("R5", "err_empty", int'(err_empty), 1);
        chk("R5", "cnt_int stays", int'(cnt_int), 0);
        idle();
        chk("R5", "err_empty clears", int'(err_empty), 0);

        // R7: fill the cc pool (5 -> 8), then one release too many
        drive(1'b0, 2'd0, 1'b1, 2'd2, 4'd0); settle();
        drive(1'b0, 2'd0, 1'b1, 2'd2, 4'd1); settle();
        drive(1'b0, 2'd0, 1'b1, 2'd2, 4'd8); settle();
        chk("R7", "cnt_cc full", int'(cnt_cc), 8);
        chk("R7", "no overflow yet", int'(err_overflow), 0);
        drive(1'b0, 2'd0, 1'b1, 2'd2, 4'd9); settle();
        chk("R7", "err_overflow", int'(err_overflow), 1);
        chk("R7", "cnt_cc held", int'(cnt_cc), 8);
        chk("R3", "cnt_int untouched", int'(cnt_int), 0);

        // R8: grant and release on the full cc pool in one cycle
        drive(1'b1, 2'd2, 1'b1, 2'd2, 4'd12);
        chk("R8", "full alloc_ok", int'(alloc_ok), 1);
        chk("R2", "cc head tag", int'(alloc_tag), 4);
        settle();
        chk("R8", "cnt_cc same", int'(cnt_cc), 8);
        chk("R8", "no overflow", int'(err_overflow), 0);

        // R2: cc order continues 5,6,7,2,0,1,8,12 (dropped 9 never appears)
        begin
            int exp_cc [8] = '{5, 6, 7, 2, 0, 1, 8, 12};
            for (int k = 0; k < 8; k++) begin
                drive(1'b1, 2'd2, 1'b0, 2'd0, 4'd0);
                chk("R2", $sformatf("cc order %0d", k), int'(alloc_tag), exp_cc[k]);
                settle();
            end
        end
        chk("R6", "free_any cc empty", int'(free_any), 3'b010);

        // R1: reset again restores the preload
        drive(1'b0, 2'd0, 1'b0, 2'd0, 4'd0);
        rst_n = 1'b0;
        settle();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "re-reset cnt_cc", int'(cnt_cc), 6);
        drive(1'b1, 2'd2, 1'b0, 2'd0, 4'd0);
        chk("R1", "re-reset cc head", int'(alloc_tag), 2);
        settle();
        idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule